// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block derives the serial clock of an I2C master from the system clock. It also produces the two per-bit timing strobes that a byte sequencer needs. A packed timing word carries three 4-bit fields. The base exponent `b` sets a prescaler of 2^b system cycles per tick. The high field `h` and the low field `l` give the tick counts of the two SCL phases minus one. One SCL period therefore spans 2^b × (h + 1 + l + 1) system cycles, plus any cycles that another device spends holding the line low. The block pulls SCL low during the low phase. During the high phase it releases the line and counts only the cycles in which the line is really high. A slave that stretches the clock therefore lengthens the high phase by exactly the number of cycles it holds the line.

The control is a four-state machine:
- `ST_IDLE`: line released, prescaler cleared.
- `ST_LOW`: line pulled low.
- `ST_HIGH`: line released and seen high, so ticks count.
- `ST_HELD`: line released but seen low, so counting is frozen.

Its transitions are:
- IDLE→LOW when `run` is sampled high.
- LOW→HIGH on the last tick of the low phase.
- HIGH→HELD and HELD→HIGH as the observed line falls and rises.
- HIGH/HELD→LOW on the last high tick when `run` is high.
- HIGH/HELD→IDLE on the last high tick when `run` is low.

The timing fields are captured only on entry to LOW, so a rewrite of the word never disturbs a period in flight. `scl_in` is assumed to be already synchronised to `clk`.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and in `ST_IDLE`, `scl_drive_low`, `change_stb` and `sample_stb` are all 0. An asynchronous reset releases the line at once.
- R2: The high count is read from `timing_word[19:16]`, the low count from `timing_word[15:12]` and the base exponent from `timing_word[3:0]`. All other bits of the word have no effect on timing.
- R3: The low phase (`scl_drive_low` = 1) lasts exactly (l + 1) × 2^b consecutive cycles.
- R4: The high phase lasts exactly (h + 1) × 2^b cycles in which the line is observed high, so an unstretched period is 2^b × (h + l + 2) cycles.
- R5: A field value of 0 yields a one-tick phase, and the maximum value 15 yields a sixteen-tick phase.
- R6: While the block releases the line but `scl_in` is 0, the phase counters hold. The high phase is lengthened by exactly the number of such cycles.
- R7: `change_stb` pulses for one cycle exactly once per low phase, at cycle offset floor(low length / 2) counted from the first low cycle (offset 0), and only while the line is driven low.
- R8: `sample_stb` pulses exactly once per high phase, at counted-high-cycle offset floor(high length / 2), and only in a cycle where the line is released and observed high.
- R9: A change of `timing_word` during a period does not alter that period. It takes effect from the next period start.
- R10: A period starts (`scl_drive_low` rises) on the clock edge that samples `run` = 1 in idle. If `run` falls during a period, that period completes and the block then stays idle with the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep generating SCL periods while high |
| timing_word | input | 32 | Packed timing fields (high 19:16, low 15:12, base 3:0) |
| scl_in | input | 1 | Observed SCL line level, synchronous to clk |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| change_stb | output | 1 | One-cycle strobe mid low phase for changing SDA |
| sample_stb | output | 1 | One-cycle strobe mid high phase for sampling SDA |

## Verification
The bench drives the fields to their extremes: both zero, where each phase is a single cycle and the strobe sits on the first cycle, and both fifteen. An off-by-one in the minus-one encoding or in the prescaler wrap would show there as wrong phase lengths. Filler bits are set around the fields to catch a decode that reads the wrong slice. A slave is made to hold the line at the start of the high phase. A design that counted released cycles rather than observed-high cycles would end the high phase early and place the sample strobe too soon. The timing word is rewritten in mid-period, and `run` is dropped in mid-period. These catch a design that applies new fields at once, or that truncates or repeats a period.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    // Width of each timing field in the packed word
    localparam int FIELD_W = 4;
    // Prescaler counter width: holds up to 2^(2^FIELD_W - 1) - 1
    localparam int PRESC_W = (1 << FIELD_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_HELD = 2'd3
    } scl_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } scl_cfg_t;

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
    import scl_timing_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HI_LSB   = 16,
    parameter int LO_LSB   = 12,
    parameter int BASE_LSB = 0
) (
    input  logic [WORD_W-1:0] word,
    output scl_cfg_t          cfg
);

    // Bits outside the three fields are reserved and carry no timing meaning
    logic unused_word_bits;

    always_comb begin
        cfg.hi   = word[HI_LSB   +: FIELD_W];
        cfg.lo   = word[LO_LSB   +: FIELD_W];
        cfg.base = word[BASE_LSB +: FIELD_W];
    end

    assign unused_word_bits = ^word;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_timing_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               en,
    input  logic [FIELD_W-1:0] base,
    output logic               tick,
    output logic [PW-1:0]      cnt
);

    localparam int LW = PW + 1;

    logic [LW-1:0] limit_wide;
    logic [PW-1:0] limit;

    always_comb begin
        limit_wide = (LW'(1) << base) - LW'(1);
        limit      = limit_wide[PW-1:0];
        tick       = en && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (en) begin
            if (tick) cnt <= '0;
            else      cnt <= cnt + PW'(1);
        end
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               scl_in,
    input  scl_cfg_t           cfg_in,
    input  logic               presc_tick,
    input  logic [PW-1:0]      presc_cnt,
    output scl_state_e         state,
    output logic [FIELD_W-1:0] tick_cnt,
    output scl_cfg_t           cfg_act,
    output logic               presc_en,
    output logic               presc_clear,
    output logic               drive_low,
    output logic               change_stb,
    output logic               sample_stb
);

    localparam int ELW = FIELD_W + PW + 1;

    scl_state_e         state_q, state_d;
    logic [FIELD_W-1:0] tick_q;
    scl_cfg_t           cfg_q;

    logic in_high, end_low, end_high, new_period;
    logic [ELW-1:0] elapsed, half_lo, half_hi;

    // Phase bookkeeping
    always_comb begin
        in_high     = (state_q == ST_HIGH) || (state_q == ST_HELD);
        presc_en    = (state_q == ST_LOW) || (in_high && scl_in);
        presc_clear = (state_q == ST_IDLE);
        end_low     = (state_q == ST_LOW) && presc_tick && (tick_q == cfg_q.lo);
        end_high    = in_high && presc_tick && (tick_q == cfg_q.hi);
        new_period  = run && ((state_q == ST_IDLE) || end_high);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (end_low) state_d = ST_HIGH;
            end
            ST_HIGH, ST_HELD: begin
                if (!scl_in)       state_d = ST_HELD;
                else if (end_high) state_d = run ? ST_LOW : ST_IDLE;
                else               state_d = ST_HIGH;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Tick counter and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            cfg_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) || end_low || end_high) tick_q <= '0;
            else if (presc_tick)                             tick_q <= tick_q + FIELD_W'(1);
            if (new_period) cfg_q <= cfg_in;
        end
    end

    // Outputs
    always_comb begin
        elapsed    = (ELW'(tick_q) << cfg_q.base) | ELW'(presc_cnt);
        half_lo    = ((ELW'(cfg_q.lo) + ELW'(1)) << cfg_q.base) >> 1;
        half_hi    = ((ELW'(cfg_q.hi) + ELW'(1)) << cfg_q.base) >> 1;
        drive_low  = (state_q == ST_LOW);
        change_stb = (state_q == ST_LOW) && (elapsed == half_lo);
        sample_stb = in_high && scl_in && (elapsed == half_hi);
        state      = state_q;
        tick_cnt   = tick_q;
        cfg_act    = cfg_q;
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HI_LSB   = 16,
    parameter int LO_LSB   = 12,
    parameter int BASE_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] timing_word,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              change_stb,
    output logic              sample_stb
);

    scl_cfg_t           cfg_dec;
    scl_cfg_t           cfg_act;
    scl_state_e         fsm_state;
    logic [FIELD_W-1:0] tick_cnt;
    logic [PRESC_W-1:0] presc_cnt;
    logic               presc_tick, presc_en, presc_clear;

    scl_cfg_decode #(
        .WORD_W  (WORD_W),
        .HI_LSB  (HI_LSB),
        .LO_LSB  (LO_LSB),
        .BASE_LSB(BASE_LSB)
    ) decode_i (
        .word(timing_word),
        .cfg (cfg_dec)
    );

    scl_prescaler #(.PW(PRESC_W)) presc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(presc_clear),
        .en   (presc_en),
        .base (cfg_act.base),
        .tick (presc_tick),
        .cnt  (presc_cnt)
    );

    scl_phase_fsm #(.PW(PRESC_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .scl_in     (scl_in),
        .cfg_in     (cfg_dec),
        .presc_tick (presc_tick),
        .presc_cnt  (presc_cnt),
        .state      (fsm_state),
        .tick_cnt   (tick_cnt),
        .cfg_act    (cfg_act),
        .presc_en   (presc_en),
        .presc_clear(presc_clear),
        .drive_low  (scl_drive_low),
        .change_stb (change_stb),
        .sample_stb (sample_stb)
    );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import scl_timing_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic               scl_in,
    input logic               scl_drive_low,
    input logic               change_stb,
    input logic               sample_stb,
    input scl_state_e         fsm_state,
    input logic [FIELD_W-1:0] tick_cnt,
    input logic [PRESC_W-1:0] presc_cnt,
    input scl_cfg_t           cfg_act
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> (!scl_drive_low && !change_stb && !sample_stb));

    // R6
    stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((fsm_state == ST_HIGH) || (fsm_state == ST_HELD)) && !scl_in)
        |=> ($stable(tick_cnt) && $stable(presc_cnt)));

    // R7
    change_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_stb |-> scl_drive_low);

    // R7
    change_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        change_stb |=> !change_stb);

    // R8
    sample_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!scl_drive_low && scl_in));

    // R9
    cfg_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_LOW) |=> $stable(cfg_act));

    // R9
    cfg_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((fsm_state == ST_HIGH) || (fsm_state == ST_HELD)) && (tick_cnt != cfg_act.hi))
        |=> $stable(cfg_act));

    // R10
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> $past(run));

endmodule

bind scl_timing_gen scl_timing_gen_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .scl_in       (scl_in),
    .scl_drive_low(scl_drive_low),
    .change_stb   (change_stb),
    .sample_stb   (sample_stb),
    .fsm_state    (fsm_state),
    .tick_cnt     (tick_cnt),
    .presc_cnt    (presc_cnt),
    .cfg_act      (cfg_act)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] word = 32'h0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        drive_low, change_stb, sample_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Open-drain line model: low when the block or another device pulls it
    assign scl_in = ~drive_low & ~hold;

    scl_timing_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .timing_word  (word),
        .scl_in       (scl_in),
        .scl_drive_low(drive_low),
        .change_stb   (change_stb),
        .sample_stb   (sample_stb)
    );

    function automatic logic [31:0] mk(input int b, input int h, input int l);
        return {12'h000, 4'(h), 4'(l), 8'h00, 4'(b)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Measures one SCL period starting at a LOW entry
    task automatic run_period(input bit aligned, input int stretch,
                              input bit do_swap, input logic [31:0] swap_word,
                              input bit do_drop, input int high_limit,
                              output int lo_len, output int hi_total, output int hi_cnt,
                              output int chg_off, output int chg_n,
                              output int smp_off, output int smp_n);
        if (!aligned) begin
            @(negedge clk);
            while (drive_low) @(negedge clk);
            while (!drive_low) @(negedge clk);
        end
        lo_len = 0; hi_total = 0; hi_cnt = 0;
        chg_off = -1; chg_n = 0; smp_off = -1; smp_n = 0;
        while (drive_low) begin
            if (change_stb) begin chg_n++; chg_off = lo_len; end
            if (sample_stb) smp_n++;
            if (lo_len == 0 && do_swap) word = swap_word;
            if (lo_len == 0 && do_drop) run = 1'b0;
            lo_len++;
            @(negedge clk);
        end
        while (!drive_low && hi_total < high_limit) begin
            hold = (hi_total < stretch);
            #1;
            if (sample_stb) begin smp_n++; smp_off = hi_cnt; end
            if (change_stb) chg_n++;
            if (scl_in) hi_cnt++;
            hi_total++;
            @(negedge clk);
        end
        hold = 1'b0;
    endtask

    task automatic expect_period(input string req, input int b, input int h, input int l,
                                 input int stretch, input int lo_len, input int hi_total,
                                 input int hi_cnt, input int chg_off, input int chg_n,
                                 input int smp_off, input int smp_n);
        int el = (l + 1) << b;
        int eh = (h + 1) << b;
        check(lo_len == el, req, "low phase length (R3)", lo_len, el);
        check(hi_cnt == eh, req, "counted high length (R4)", hi_cnt, eh);
        check(hi_total == eh + stretch, req, "released length (R6)", hi_total, eh + stretch);
        check(chg_n == 1, req, "change strobe count (R7)", chg_n, 1);
        check(chg_off == (el >> 1), req, "change strobe offset (R7)", chg_off, el >> 1);
        check(smp_n == 1, req, "sample strobe count (R8)", smp_n, 1);
        check(smp_off == (eh >> 1), req, "sample strobe offset (R8)", smp_off, eh >> 1);
    endtask

    task automatic std_period(input string req, input logic [31:0] w,
                              input int b, input int h, input int l, input int stretch);
        int lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n;
        word = w;
        run_period(1'b0, stretch, 1'b0, 32'h0, 1'b0, 1 << 20,
                   lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n);
        expect_period(req, b, h, l, stretch, lo_len, hi_total, hi_cnt,
                      chg_off, chg_n, smp_off, smp_n);
    endtask

    task automatic t_reset();
        int busy;
        check(drive_low == 1'b0, "R1", "drive in reset", drive_low, 0);
        check(change_stb == 1'b0 && sample_stb == 1'b0, "R1", "strobes in reset",
              change_stb + sample_stb, 0);
        @(negedge clk); rst_n = 1'b1;
        busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (drive_low || change_stb || sample_stb) busy++;
        end
        check(busy == 0, "R1", "idle activity cycles", busy, 0);
        word = mk(2, 3, 3);
        run = 1'b1;
        @(negedge clk);
        check(drive_low == 1'b1, "R10", "low one edge after run", drive_low, 1);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(drive_low == 1'b0, "R1", "async reset releases line", drive_low, 0);
        run = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;
    endtask

    task automatic t_swap();
        int lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n;
        word = mk(1, 4, 2);
        run_period(1'b0, 0, 1'b1, mk(0, 1, 5), 1'b0, 1 << 20,
                   lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n);
        expect_period("R9 old fields kept", 1, 4, 2, 0, lo_len, hi_total, hi_cnt,
                      chg_off, chg_n, smp_off, smp_n);
        run_period(1'b1, 0, 1'b0, 32'h0, 1'b0, 1 << 20,
                   lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n);
        expect_period("R9 new fields next period", 0, 1, 5, 0, lo_len, hi_total, hi_cnt,
                      chg_off, chg_n, smp_off, smp_n);
    endtask

    task automatic t_drop();
        int lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n;
        int eh;
        eh = 3 << 1;
        word = mk(1, 2, 1);
        run_period(1'b0, 0, 1'b0, 32'h0, 1'b1, eh + 40,
                   lo_len, hi_total, hi_cnt, chg_off, chg_n, smp_off, smp_n);
        check(lo_len == (2 << 1), "R10", "low completes after run drop", lo_len, 4);
        check(hi_total == eh + 40, "R10", "no restart after run drop", hi_total, eh + 40);
        check(smp_n == 1, "R10", "sample once in final period", smp_n, 1);
        run = 1'b1;
        std_period("R10 restart", mk(1, 2, 1), 1, 2, 1, 0);
    endtask

    initial begin
        t_reset();
        std_period("R5 zero fields", mk(0, 0, 0), 0, 0, 0, 0);
        std_period("R3 R4 recommended split", mk(2, 8, 7), 2, 8, 7, 0);
        std_period("R5 max fields", mk(0, 15, 15), 0, 15, 15, 0);
        std_period("R2 filler bits ignored", 32'hFFF1_3FF1, 1, 1, 3, 0);
        std_period("R6 stretched high", mk(1, 3, 2), 1, 3, 2, 5);
        t_swap();
        t_drop();
        std_period("R4 large base", mk(10, 1, 0), 10, 1, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule